// File: doc/BRIEF.md
# MSI Indicator Bit Setter

This block terminates writes to a function's message-signalled-interrupt doorbell. The written word is split into an index, which is the upper field, and a vector number, which is the low field. For a bound and enabled function, the block marks the interrupt in two places in memory. First it sets a per-vector indicator bit. Then it sets a per-function summary bit. Each bit is set through a byte-wide read-modify-write sequence on a simple request/acknowledge memory port.

An adapter interrupt pulse is raised only when the summary byte read back as zero. Repeated messages are therefore merged until software clears the summary. A doorbell with no bound function produces an error event instead. A memory fault during an update produces an indicator-fault error event. Doorbell reads always return all ones. Only one doorbell write is handled at a time, which keeps each read-modify-write atomic with respect to other doorbell traffic.

Top module: `msi_ind_setter`

## Requirements
- R1: An accepted write splits `wr_data_i` into a vector number, `wr_data_i[VEC_W-1:0]` (11 bits by default), and an index, `wr_data_i[DW-1:VEC_W]`.
- R2: A write accepted while `bound_i` is low touches no memory. One cycle later it pulses `err_valid_o` with `err_code_o`=1, `err_idx_o`=index, `err_addr_o`=doorbell address and `err_info_o`=vector shifted left by `ERR_VEC_SHIFT` (4).
- R3: A write accepted while `bound_i` is high and `enabled_i` is low is ignored. It causes no memory access, no event and no interrupt.
- R4: The indicator bit position is `ind_off_i` + vector. It is written at byte address `ind_base_i` + position/8, with mask 8'h80 >> (position mod 8), so bits are numbered MSB first.
- R5: The summary bit uses the same rule, with `sum_base_i` and `sum_off_i` and no vector term.
- R6: Each bit is set by a read of its byte, followed at once by a write of (old | mask) to the same address. The whole indicator sequence comes before the summary sequence.
- R7: When the summary write completes and the summary byte read as 8'h00, `irq_o` pulses for one cycle, with `irq_isc_o` equal to the `isc_i` captured when the write was accepted. Otherwise no interrupt is raised.
- R8: A read acknowledged with `mem_err_i` high pulses `err_valid_o` with `err_code_o`=2 and index, address and info all zero, and that byte is not written. A fault on the indicator still lets the summary update proceed. A fault on the summary suppresses the interrupt.
- R9: A `rd_req_i` pulse is answered in the next cycle with `rd_valid_o` high and `rd_data_o` all ones.
- R10: `ready_o` is low from acceptance until the last memory access completes. `wr_valid_i` while `ready_o` is low has no effect.
- R11: While `mem_req_o` is high and not acknowledged, the request, its address and its direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Doorbell write strobe |
| wr_addr_i | input | AW | Doorbell address of the write |
| wr_data_i | input | DW | Doorbell write data (index and vector) |
| ready_o | output | 1 | High when a doorbell write can be accepted |
| rd_req_i | input | 1 | Doorbell read strobe |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | DW | Read response data (all ones) |
| bound_i | input | 1 | A function is bound to the doorbell |
| enabled_i | input | 1 | Bound function is in the enabled state |
| ind_base_i | input | AW | Indicator area byte address |
| ind_off_i | input | OFF_W | Indicator bit offset |
| sum_base_i | input | AW | Summary area byte address |
| sum_off_i | input | OFF_W | Summary bit offset |
| isc_i | input | ISC_W | Interrupt subclass of the function |
| mem_req_o | output | 1 | Memory byte access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with ack |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access could not be mapped, valid with ack |
| irq_o | output | 1 | Adapter interrupt pulse |
| irq_isc_o | output | ISC_W | Subclass of the pulse |
| err_valid_o | output | 1 | Error event pulse |
| err_code_o | output | 2 | 1 = no function bound, 2 = indicator access fault |
| err_idx_o | output | DW-VEC_W | Index carried by the event |
| err_addr_o | output | AW | Doorbell address carried by the event |
| err_info_o | output | DW | Vector number field of the event |

## Verification
The assertions assume four things about the inputs:
- The memory side answers every request with exactly one `mem_ack_i` pulse.
- `mem_err_i` is raised only together with the ack of a read.
- `mem_ack_i` is never raised without a request.
- The configuration inputs hold steady while a write is accepted.

The bench's memory model acknowledges only a pending request, after a chosen latency, and drops `mem_ack_i` on the following half-cycle. Faults are injected only on read addresses. Configuration is changed only while `ready_o` is high and no access is outstanding. The bench also keeps the indicator and summary bytes apart whenever a summary fault is injected.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IND_RD,
    ST_IND_WR,
    ST_SUM_RD,
    ST_SUM_WR
  } rmw_state_e;

  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_NO_FUNC   = 2'd1,
    EV_IND_FAULT = 2'd2
  } err_code_e;

  localparam int unsigned NUM_TGT = 2;
  localparam int unsigned TGT_IND = 0;
  localparam int unsigned TGT_SUM = 1;
endpackage

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned VEC_W = 11
) (
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [AW-1:0]    byte_addr_o,
  output logic [7:0]       mask_o
);
  localparam int unsigned POS_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

  logic [POS_W-1:0] pos;

  always_comb begin
    pos         = POS_W'(off_i) + POS_W'(vec_i);
    byte_addr_o = base_i + AW'(pos >> 3);
    mask_o      = 8'h80 >> pos[2:0];   // MSB-first bit numbering
  end
endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq
  import msi_ind_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [NUM_TGT-1:0][AW-1:0]   tgt_addr_i,
  input  logic [NUM_TGT-1:0][7:0]      tgt_mask_i,
  output logic                         busy_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [AW-1:0]                mem_addr_o,
  output logic [7:0]                   mem_wdata_o,
  input  logic [7:0]                   mem_rdata_i,
  input  logic                         mem_ack_i,
  input  logic                         mem_err_i,
  output logic                         ind_fault_o,
  output logic                         fire_o
);
  rmw_state_e                 state_q;
  logic [NUM_TGT-1:0][AW-1:0] addr_q;
  logic [NUM_TGT-1:0][7:0]    mask_q;
  logic [7:0]                 wbyte_q;
  logic                       sum_zero_q;
  logic                       on_sum;
  logic                       is_rd;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[t] <= '0;
        mask_q[t] <= '0;
      end else if (start_i && state_q == ST_IDLE) begin
        addr_q[t] <= tgt_addr_i[t];
        mask_q[t] <= tgt_mask_i[t];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wbyte_q    <= '0;
      sum_zero_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_IND_RD;
        ST_IND_RD: if (mem_ack_i) begin
          if (mem_err_i) state_q <= ST_SUM_RD;
          else begin
            wbyte_q <= mem_rdata_i | mask_q[TGT_IND];
            state_q <= ST_IND_WR;
          end
        end
        ST_IND_WR: if (mem_ack_i) state_q <= ST_SUM_RD;
        ST_SUM_RD: if (mem_ack_i) begin
          if (mem_err_i) state_q <= ST_IDLE;
          else begin
            wbyte_q    <= mem_rdata_i | mask_q[TGT_SUM];
            sum_zero_q <= (mem_rdata_i == 8'h00);
            state_q    <= ST_SUM_WR;
          end
        end
        ST_SUM_WR: if (mem_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    on_sum      = (state_q == ST_SUM_RD) || (state_q == ST_SUM_WR);
    is_rd       = (state_q == ST_IND_RD) || (state_q == ST_SUM_RD);
    busy_o      = (state_q != ST_IDLE);
    mem_req_o   = busy_o;
    mem_we_o    = busy_o && !is_rd;
    mem_addr_o  = on_sum ? addr_q[TGT_SUM] : addr_q[TGT_IND];
    mem_wdata_o = wbyte_q;
    ind_fault_o = mem_ack_i && mem_err_i && is_rd;
    fire_o      = mem_ack_i && (state_q == ST_SUM_WR) && sum_zero_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R11

  AST_RMW_SAME_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && !mem_err_i) |=>
      (mem_req_o && mem_we_o && $stable(mem_addr_o) &&
       ((mem_wdata_o & $past(mem_rdata_i)) == $past(mem_rdata_i)))); // R6

  AST_FIRE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (mem_req_o && mem_we_o && mem_ack_i)); // R7
endmodule

// File: rtl/msi_event_gen.sv
module msi_event_gen
  import msi_ind_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned DW            = 32,
  parameter int unsigned VEC_W         = 11,
  parameter int unsigned ISC_W         = 3,
  parameter int unsigned ERR_VEC_SHIFT = 4,
  localparam int unsigned IDX_W        = DW - VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             no_func_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             ind_fault_i,
  input  logic             fire_i,
  input  logic [ISC_W-1:0] isc_i,
  output logic             irq_o,
  output logic [ISC_W-1:0] irq_isc_o,
  output logic             err_valid_o,
  output logic [1:0]       err_code_o,
  output logic [IDX_W-1:0] err_idx_o,
  output logic [AW-1:0]    err_addr_o,
  output logic [DW-1:0]    err_info_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      irq_isc_o   <= '0;
      err_valid_o <= 1'b0;
      err_code_o  <= EV_NONE;
      err_idx_o   <= '0;
      err_addr_o  <= '0;
      err_info_o  <= '0;
    end else begin
      irq_o       <= fire_i;
      if (fire_i) irq_isc_o <= isc_i;
      err_valid_o <= no_func_i || ind_fault_i;
      if (no_func_i) begin
        err_code_o <= EV_NO_FUNC;
        err_idx_o  <= idx_i;
        err_addr_o <= addr_i;
        err_info_o <= DW'(vec_i) << ERR_VEC_SHIFT;
      end else if (ind_fault_i) begin
        err_code_o <= EV_IND_FAULT;
        err_idx_o  <= '0;
        err_addr_o <= '0;
        err_info_o <= '0;
      end
    end
  end

  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(no_func_i && ind_fault_i)); // R2

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
endmodule

// File: rtl/msi_ind_setter.sv
module msi_ind_setter
  import msi_ind_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned DW            = 32,
  parameter int unsigned VEC_W         = 11,
  parameter int unsigned OFF_W         = 16,
  parameter int unsigned ISC_W         = 3,
  parameter int unsigned ERR_VEC_SHIFT = 4,
  localparam int unsigned IDX_W        = DW - VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             ready_o,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  input  logic             bound_i,
  input  logic             enabled_i,
  input  logic [AW-1:0]    ind_base_i,
  input  logic [OFF_W-1:0] ind_off_i,
  input  logic [AW-1:0]    sum_base_i,
  input  logic [OFF_W-1:0] sum_off_i,
  input  logic [ISC_W-1:0] isc_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  output logic             irq_o,
  output logic [ISC_W-1:0] irq_isc_o,
  output logic             err_valid_o,
  output logic [1:0]       err_code_o,
  output logic [IDX_W-1:0] err_idx_o,
  output logic [AW-1:0]    err_addr_o,
  output logic [DW-1:0]    err_info_o
);
  logic [VEC_W-1:0]           vec;
  logic [IDX_W-1:0]           idx;
  logic                       accept, start, no_func, busy;
  logic                       ind_fault, fire;
  logic [NUM_TGT-1:0][AW-1:0]    base_v, loc_addr;
  logic [NUM_TGT-1:0][OFF_W-1:0] off_v;
  logic [NUM_TGT-1:0][VEC_W-1:0] vec_v;
  logic [NUM_TGT-1:0][7:0]       loc_mask;
  logic [ISC_W-1:0]           isc_q;
  logic                       rd_valid_q;

  always_comb begin
    vec     = wr_data_i[VEC_W-1:0];
    idx     = wr_data_i[DW-1:VEC_W];
    ready_o = !busy;
    accept  = wr_valid_i && ready_o;
    start   = accept && bound_i && enabled_i;
    no_func = accept && !bound_i;
    base_v[TGT_IND] = ind_base_i;
    off_v[TGT_IND]  = ind_off_i;
    vec_v[TGT_IND]  = vec;
    base_v[TGT_SUM] = sum_base_i;
    off_v[TGT_SUM]  = sum_off_i;
    vec_v[TGT_SUM]  = '0;   // summary bit is per function
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_loc
    msi_bit_locator #(.AW(AW), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_loc (
      .base_i      (base_v[t]),
      .off_i       (off_v[t]),
      .vec_i       (vec_v[t]),
      .byte_addr_o (loc_addr[t]),
      .mask_o      (loc_mask[t])
    );
  end

  msi_rmw_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .tgt_addr_i  (loc_addr),
    .tgt_mask_i  (loc_mask),
    .busy_o      (busy),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i),
    .ind_fault_o (ind_fault),
    .fire_o      (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isc_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (start) isc_q <= isc_i;
      rd_valid_q <= rd_req_i;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_valid_q ? '1 : '0;

  msi_event_gen #(
    .AW(AW), .DW(DW), .VEC_W(VEC_W), .ISC_W(ISC_W), .ERR_VEC_SHIFT(ERR_VEC_SHIFT)
  ) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .no_func_i   (no_func),
    .idx_i       (idx),
    .vec_i       (vec),
    .addr_i      (wr_addr_i),
    .ind_fault_i (ind_fault),
    .fire_i      (fire),
    .isc_i       (isc_q),
    .irq_o       (irq_o),
    .irq_isc_o   (irq_isc_o),
    .err_valid_o (err_valid_o),
    .err_code_o  (err_code_o),
    .err_idx_o   (err_idx_o),
    .err_addr_o  (err_addr_o),
    .err_info_o  (err_info_o)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R10

  AST_DISABLED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && ready_o && bound_i && !enabled_i) |=>
      (ready_o && !mem_req_o && !err_valid_o && !irq_o)); // R3

  AST_NO_FUNC_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && ready_o && !bound_i) |=>
      (ready_o && !mem_req_o && err_valid_o && err_code_o == 2'd1)); // R2

  AST_RD_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (rd_valid_o && rd_data_o == '1)); // R9
endmodule

// File: tb/msi_ind_setter_tb_top.sv
module msi_ind_setter_tb_top;
  localparam int AW = 32, DW = 32, VEC_W = 11, OFF_W = 16, ISC_W = 3;
  localparam int IDX_W = DW - VEC_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, rd_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic ready_o, rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic bound_i = 1'b0, enabled_i = 1'b0;
  logic [AW-1:0] ind_base_i = '0, sum_base_i = '0;
  logic [OFF_W-1:0] ind_off_i = '0, sum_off_i = '0;
  logic [ISC_W-1:0] isc_i = '0;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] mem_rdata_i = '0;
  logic mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic irq_o, err_valid_o;
  logic [ISC_W-1:0] irq_isc_o;
  logic [1:0] err_code_o;
  logic [IDX_W-1:0] err_idx_o;
  logic [AW-1:0] err_addr_o;
  logic [DW-1:0] err_info_o;

  always #10 clk = ~clk;   // 50 MHz

  msi_ind_setter dut_i (.*, .clk_i(clk));

  typedef struct { bit we; logic [AW-1:0] addr; logic [7:0] wdata; string tag; } op_t;
  typedef struct { bit is_irq; logic [ISC_W-1:0] isc; logic [1:0] code;
                   logic [IDX_W-1:0] idx; logic [AW-1:0] addr; logic [DW-1:0] info; string tag; } ev_t;

  op_t exp_ops[$];
  ev_t exp_evs[$];
  logic [7:0] mem [0:511];
  int lat = 0, wcnt = 0;
  bit fault_on = 0;
  logic [AW-1:0] fault_addr = '0;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory responder and access scoreboard
  always @(negedge clk) begin : resp
    op_t e;
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      mem_err_i = 1'b0;
    end else if (rst_ni && mem_req_o) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        mem_ack_i = 1'b1;
        if (exp_ops.size() == 0)
          chk(1'b0, "R3", "unexpected memory access", mem_addr_o, 0);
        else begin
          e = exp_ops.pop_front();
          chk(mem_we_o == e.we, "R6", "access direction", mem_we_o, e.we);
          chk(mem_addr_o == e.addr, e.tag, "byte address", mem_addr_o, e.addr);
          if (e.we) chk(mem_wdata_o == e.wdata, e.tag, "written byte", mem_wdata_o, e.wdata);
        end
        if (mem_we_o) mem[mem_addr_o[8:0]] = mem_wdata_o;
        else if (fault_on && mem_addr_o == fault_addr) mem_err_i = 1'b1;
        else mem_rdata_i = mem[mem_addr_o[8:0]];
      end
    end
  end

  // event monitor
  always @(negedge clk) begin : evmon
    ev_t e;
    if (rst_ni && (irq_o || err_valid_o)) begin
      if (exp_evs.size() == 0)
        chk(1'b0, "R7", "unexpected event", {irq_o, err_valid_o}, 0);
      else begin
        e = exp_evs.pop_front();
        chk(irq_o == e.is_irq, e.tag, "event kind irq", irq_o, e.is_irq);
        if (e.is_irq) chk(irq_isc_o == e.isc, "R7", "interrupt subclass", irq_isc_o, e.isc);
        else begin
          chk(err_code_o == e.code, e.tag, "error code", err_code_o, e.code);
          chk(err_idx_o == e.idx, "R1", "error index", err_idx_o, e.idx);
          chk(err_addr_o == e.addr, e.tag, "error address", err_addr_o, e.addr);
          chk(err_info_o == e.info, e.tag, "error vector field", err_info_o, e.info);
        end
      end
    end
  end

  task automatic push_err(input logic [1:0] code, input logic [IDX_W-1:0] idx,
                          input logic [AW-1:0] a, input logic [DW-1:0] info, input string tag);
    exp_evs.push_back('{is_irq: 1'b0, isc: '0, code: code, idx: idx, addr: a, info: info, tag: tag});
  endtask

  // fsel: 0 none, 1 fault on indicator read, 2 fault on summary read
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit bound,
                          input bit en, input int fsel, input bit poke, input string tag);
    logic [VEC_W-1:0] vec;
    logic [IDX_W-1:0] idx;
    logic [OFF_W:0] ipos, spos;
    logic [AW-1:0] ia, sa;
    logic [7:0] im, sm, iold, sold;
    vec = d[VEC_W-1:0];
    idx = d[DW-1:VEC_W];
    bound_i = bound;
    enabled_i = en;
    if (!bound) push_err(2'd1, idx, a, DW'(vec) << 4, "R2");
    else if (en) begin
      ipos = {1'b0, ind_off_i} + (OFF_W+1)'(vec);
      spos = {1'b0, sum_off_i};
      ia = ind_base_i + AW'(ipos >> 3);
      im = 8'h80 >> ipos[2:0];
      sa = sum_base_i + AW'(spos >> 3);
      sm = 8'h80 >> spos[2:0];
      fault_on = (fsel != 0);
      fault_addr = (fsel == 1) ? ia : sa;
      iold = mem[ia[8:0]];
      exp_ops.push_back('{we: 1'b0, addr: ia, wdata: '0, tag: "R4"});
      if (fsel == 1) push_err(2'd2, '0, '0, '0, "R8");
      else exp_ops.push_back('{we: 1'b1, addr: ia, wdata: iold | im, tag: "R4"});
      sold = (fsel != 1 && sa == ia) ? (iold | im) : mem[sa[8:0]];
      exp_ops.push_back('{we: 1'b0, addr: sa, wdata: '0, tag: "R5"});
      if (fsel == 2) push_err(2'd2, '0, '0, '0, "R8");
      else begin
        exp_ops.push_back('{we: 1'b1, addr: sa, wdata: sold | sm, tag: "R5"});
        if (sold == 8'h00)
          exp_evs.push_back('{is_irq: 1'b1, isc: isc_i, code: '0, idx: '0, addr: '0, info: '0, tag: "R7"});
      end
    end
    @(negedge clk);
    wr_addr_i = a; wr_data_i = d; wr_valid_i = 1'b1;
    @(negedge clk);
    wr_valid_i = 1'b0;
    if (poke) begin   // R10: writes while busy must be dropped
      wr_data_i = d ^ 32'h5; wr_valid_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_valid_i = 1'b0;
    end
    while (!ready_o || exp_ops.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_ops.size() == 0, tag, "missing memory accesses", exp_ops.size(), 0);
    chk(exp_evs.size() == 0, tag, "missing events", exp_evs.size(), 0);
    fault_on = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state (R10)
    chk(ready_o == 1'b1, "R10", "ready after reset", ready_o, 1);
    chk(mem_req_o == 1'b0, "R11", "no request after reset", mem_req_o, 0);
    chk(irq_o == 1'b0 && err_valid_o == 1'b0, "R7", "no events after reset", {irq_o, err_valid_o}, 0);

    // R9 doorbell read
    rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
    chk(rd_valid_o == 1'b1, "R9", "read valid", rd_valid_o, 1);
    chk(rd_data_o == 32'hFFFF_FFFF, "R9", "read data", rd_data_o, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(rd_valid_o == 1'b0, "R9", "read valid drops", rd_valid_o, 0);

    ind_base_i = 32'h10; ind_off_i = 16'd0; sum_base_i = 32'h40; sum_off_i = 16'd5; isc_i = 3'd5;
    // R1 R4 R5 R7 basic: vec 3, index 7, summary clear -> interrupt
    do_write(32'h1000, (32'd7 << 11) | 32'd3, 1, 1, 0, 0, "R7");
    // repeated message with summary set: merged, no interrupt (R7)
    lat = 2;
    do_write(32'h1000, (32'd7 << 11) | 32'd3, 1, 1, 0, 0, "R7");
    // vector crossing bytes: off 6 + vec 13 = pos 19 (R4)
    ind_off_i = 16'd6; lat = 1;
    do_write(32'h1000, 32'd13, 1, 1, 0, 0, "R4");
    // largest vector (R1 R4)
    ind_off_i = 16'd0; lat = 0;
    do_write(32'h1000, 32'hFFFF_F800 | 32'd2047, 1, 1, 0, 0, "R1");
    // software clears summary -> interrupt again (R7)
    mem[9'h40] = 8'h00; isc_i = 3'd2;
    do_write(32'h1000, 32'd1, 1, 1, 0, 0, "R7");
    // summary byte nonzero in another bit: kept, no interrupt (R5 R7)
    mem[9'h40] = 8'h81; sum_off_i = 16'd10; sum_base_i = 32'h3F;
    do_write(32'h1000, 32'd4, 1, 1, 0, 0, "R5");
    // unbound doorbell -> error event, no access (R2)
    do_write(32'h2468, (32'd1234 << 11) | 32'd1500, 0, 1, 0, 0, "R2");
    // bound but not enabled -> ignored (R3)
    do_write(32'h1000, 32'd9, 1, 0, 0, 0, "R3");
    // indicator fault: error, summary still updated (R8)
    mem[9'h40] = 8'h00; sum_base_i = 32'h40; sum_off_i = 16'd0;
    do_write(32'h1000, 32'd20, 1, 1, 1, 0, "R8");
    // summary fault: error, no interrupt (R8)
    mem[9'h40] = 8'h00;
    do_write(32'h1000, 32'd21, 1, 1, 2, 0, "R8");
    // writes while busy are dropped (R10), with slow memory (R11)
    lat = 3; mem[9'h40] = 8'h00;
    do_write(32'h1000, 32'd30, 1, 1, 0, 1, "R10");
    // indicator and summary in the same byte (R6)
    lat = 0; ind_base_i = 32'h80; ind_off_i = 16'd0; sum_base_i = 32'h80; sum_off_i = 16'd7;
    do_write(32'h1000, 32'd2, 1, 1, 0, 0, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule